// File: doc/BRIEF.md
# Segment-Mapped Address Translator with Privilege Fencing

This unit sits between a processor's fetch/load/store port and the memory bus. Each request carries a 32-bit virtual address, an access kind and the privilege level of the issuing code. The unit answers with a 29-bit physical address, a cacheable attribute and an exception flag with a 2-bit cause. There is no lookup table. The upper half of the virtual space holds four 512 MB kernel windows. The first two windows alias the same physical range and differ only in cacheability. The other two windows fault.

The lower half is the user segment and stays closed until kernel code opens it. Once open, a user address is an offset into one of two partitions that kernel code programs at run time: one partition for data, one for instruction fetch. The offset is added to the partition base. An offset past the partition size faults. A result that lands in the protected top of physical memory (special-function registers and boot flash) also faults.

Configuration writes use the same request channel as a fourth access kind, so register updates and translations keep strict order. Results leave through a single output register, with valid/ready on both sides.

Top module: `addr_xlate_unit`

## Requirements
- R1: Every accepted request produces exactly one response one cycle later. `req_ready_o` is high exactly when the output register is empty or is being drained in that cycle. While `rsp_ready_i` is low, a pending response holds its valid, address, attribute and cause unchanged.
- R2: Kind 0 is fetch, 1 is read and 2 is write. For these kinds in kernel mode, an address in 0x8000_0000–0x9FFF_FFFF translates to its low 29 bits with `rsp_cached_o`=1 and cause 0.
- R3: For the same kinds in kernel mode, an address in 0xA000_0000–0xBFFF_FFFF translates to its low 29 bits with `rsp_cached_o`=0 and cause 0.
- R4: For the same kinds in kernel mode, an address at or above 0xC000_0000 faults with cause 1 (unmapped or reserved).
- R5: An access with bit 31 clear faults with cause 1 while the user-enable bit is 0, whatever the privilege mode.
- R6: With user enable set, a fetch uses the program partition and a read or write uses the data partition. The offset is bits 30:0 of the address. When offset < size, the result is base + offset with `rsp_cached_o`=1. When offset ≥ size, the access faults with cause 2.
- R7: A user-segment result at or above `PROT_BASE` (default 0x1F80_0000), or beyond 29 bits, faults with cause 2.
- R8: In user mode (`req_user_i`=1), any fetch, read or write with bit 31 set faults with cause 3. Cause 3 takes precedence over cause 1.
- R9: Kind 3 in kernel mode writes `req_wdata_i` into the register chosen by bits 2:0 of the address. Selector 0 is the mode register (bit 0 = user enable), 1 the data base, 2 the data size, 3 the program base and 4 the program size. Selectors 5–7 change nothing. The response carries cause 0. The new value governs the next accepted request.
- R10: Kind 3 in user mode changes no register and responds with cause 3.
- R11: `rsp_exc_o` is high exactly when the cause is nonzero. While it is high, `rsp_paddr_o` is 0 and `rsp_cached_o` is 0. Configuration responses carry address 0, uncached.
- R12: After reset no response is pending, `req_ready_o` is high, user enable is 0, and all bases and sizes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| req_vaddr_i | input | 32 | Virtual address, or register selector in bits 2:0 for kind 3 |
| req_kind_i | input | 2 | 0 fetch, 1 read, 2 write, 3 configuration write |
| req_user_i | input | 1 | 1 when the issuing code runs in user mode |
| req_wdata_i | input | 29 | Configuration write data |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response taken |
| rsp_paddr_o | output | 29 | Physical address, 0 on exception |
| rsp_cached_o | output | 1 | Access may go through the cache |
| rsp_exc_o | output | 1 | Exception raised |
| rsp_cause_o | output | 2 | 0 none, 1 unmapped/reserved, 2 fenced, 3 privilege |

## Verification
Two things can happen on the same clock edge. The output register can hand off a response and load the next one, and a configuration write can land while the request right behind it is evaluated against the updated partition. The bench drives back-to-back requests under random response backpressure. It mixes configuration writes among fetches, reads and writes to every segment. A behavioural model updates its own register copy at the moment of acceptance and keeps a queue of expected responses. On every cycle the model judges the ready rule, whether a response is pending, and the exact contents of each response that is drained.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 29;
  localparam int SEL_W   = 3;
  localparam int N_WORDS = 4; // data base, data size, prog base, prog size

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_CFG   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_UNMAP = 2'd1,
    EXC_FENCE = 2'd2,
    EXC_PRIV  = 2'd3
  } cause_e;

  typedef struct packed {
    logic [PA_W-1:0] paddr;
    logic            cached;
    cause_e          cause;
  } xlate_t;
endpackage

// File: rtl/axu_cfg_regs.sv
module axu_cfg_regs
  import addr_xlate_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [PA_W-1:0] wdata_i,
  output logic            user_en_o,
  output logic [PA_W-1:0] dat_base_o,
  output logic [PA_W-1:0] dat_size_o,
  output logic [PA_W-1:0] prg_base_o,
  output logic [PA_W-1:0] prg_size_o
);
  logic [PA_W-1:0] word_q [N_WORDS];
  logic            uen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uen_q <= 1'b0;
      for (int i = 0; i < N_WORDS; i++) word_q[i] <= '0;
    end else if (we_i) begin
      if (sel_i == '0) uen_q <= wdata_i[0];
      for (int i = 0; i < N_WORDS; i++)
        if (sel_i == SEL_W'(i + 1)) word_q[i] <= wdata_i;
    end
  end

  assign user_en_o  = uen_q;
  assign dat_base_o = word_q[0];
  assign dat_size_o = word_q[1];
  assign prg_base_o = word_q[2];
  assign prg_size_o = word_q[3];
endmodule

// File: rtl/axu_kseg_decode.sv
module axu_kseg_decode
  import addr_xlate_pkg::*;
(
  input  logic [1:0]      seg_i,    // vaddr[30:29] within kernel half
  input  logic [PA_W-1:0] low_i,
  output logic            mapped_o,
  output logic            cached_o,
  output logic [PA_W-1:0] paddr_o
);
  always_comb begin
    mapped_o = 1'b0;
    cached_o = 1'b0;
    paddr_o  = '0;
    unique case (seg_i)
      2'b00: begin mapped_o = 1'b1; cached_o = 1'b1; paddr_o = low_i; end
      2'b01: begin mapped_o = 1'b1; cached_o = 1'b0; paddr_o = low_i; end
      default: ; // reserved / absent windows
    endcase
  end
endmodule

// File: rtl/axu_user_fence.sv
module axu_user_fence
  import addr_xlate_pkg::*;
#(
  parameter logic [PA_W-1:0] PROT_BASE = 29'h1F80_0000
) (
  input  logic [VA_W-2:0] off_i,
  input  logic [PA_W-1:0] base_i,
  input  logic [PA_W-1:0] size_i,
  output logic            fault_o,
  output logic [PA_W-1:0] paddr_o
);
  localparam int OFF_W = VA_W - 1;

  logic            in_part;
  logic [PA_W:0]   sum;

  assign in_part = off_i < OFF_W'(size_i);
  assign sum     = {1'b0, base_i} + {1'b0, off_i[PA_W-1:0]};
  assign fault_o = !in_part || sum[PA_W] || (sum[PA_W-1:0] >= PROT_BASE);
  assign paddr_o = sum[PA_W-1:0];
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import addr_xlate_pkg::*;
#(
  parameter logic [28:0] PROT_BASE = 29'h1F80_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_vaddr_i,
  input  logic [1:0]  req_kind_i,
  input  logic        req_user_i,
  input  logic [28:0] req_wdata_i,
  output logic        rsp_valid_o,
  input  logic        rsp_ready_i,
  output logic [28:0] rsp_paddr_o,
  output logic        rsp_cached_o,
  output logic        rsp_exc_o,
  output logic [1:0]  rsp_cause_o
);
  acc_e            kind;
  logic            fire, cfg_we;
  logic            user_en;
  logic [PA_W-1:0] dat_base, dat_size, prg_base, prg_size;
  logic            k_mapped, k_cached;
  logic [PA_W-1:0] k_paddr, u_paddr, sel_base, sel_size;
  logic            u_fault;
  xlate_t          res, rsp_q;
  logic            rsp_valid_q;

  assign kind        = acc_e'(req_kind_i);
  assign req_ready_o = !rsp_valid_q || rsp_ready_i;
  assign fire        = req_valid_i && req_ready_o;
  assign cfg_we      = fire && (kind == ACC_CFG) && !req_user_i;

  axu_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we),
    .sel_i      (req_vaddr_i[SEL_W-1:0]),
    .wdata_i    (req_wdata_i),
    .user_en_o  (user_en),
    .dat_base_o (dat_base),
    .dat_size_o (dat_size),
    .prg_base_o (prg_base),
    .prg_size_o (prg_size)
  );

  axu_kseg_decode u_kseg (
    .seg_i    (req_vaddr_i[VA_W-2:VA_W-3]),
    .low_i    (req_vaddr_i[PA_W-1:0]),
    .mapped_o (k_mapped),
    .cached_o (k_cached),
    .paddr_o  (k_paddr)
  );

  // fetch walks the program partition, loads/stores the data partition
  assign sel_base = (kind == ACC_FETCH) ? prg_base : dat_base;
  assign sel_size = (kind == ACC_FETCH) ? prg_size : dat_size;

  axu_user_fence #(.PROT_BASE(PROT_BASE)) u_fence (
    .off_i   (req_vaddr_i[VA_W-2:0]),
    .base_i  (sel_base),
    .size_i  (sel_size),
    .fault_o (u_fault),
    .paddr_o (u_paddr)
  );

  always_comb begin
    res = '0;
    if (kind == ACC_CFG) begin
      if (req_user_i) res.cause = EXC_PRIV;
    end else if (req_vaddr_i[VA_W-1]) begin
      if (req_user_i)     res.cause = EXC_PRIV;
      else if (!k_mapped) res.cause = EXC_UNMAP;
      else begin
        res.paddr  = k_paddr;
        res.cached = k_cached;
      end
    end else begin
      if (!user_en)     res.cause = EXC_UNMAP;
      else if (u_fault) res.cause = EXC_FENCE;
      else begin
        res.paddr  = u_paddr;
        res.cached = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
    end else begin
      if (fire) begin
        rsp_valid_q <= 1'b1;
        rsp_q       <= res;
      end else if (rsp_ready_i) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_paddr_o  = rsp_q.paddr;
  assign rsp_cached_o = rsp_q.cached;
  assign rsp_cause_o  = rsp_q.cause;
  assign rsp_exc_o    = rsp_q.cause != EXC_NONE;
endmodule

// File: rtl/addr_xlate_unit_chk.sv
module addr_xlate_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [31:0] req_vaddr_i,
  input logic [1:0]  req_kind_i,
  input logic        req_user_i,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [28:0] rsp_paddr_o,
  input logic        rsp_cached_o,
  input logic        rsp_exc_o,
  input logic [1:0]  rsp_cause_o
);
  logic fire_k;
  assign fire_k = req_valid_i && req_ready_o && (req_kind_i != 2'd3);

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o)
      && $stable(rsp_cached_o) && $stable(rsp_cause_o));

  p_drain_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i && !req_valid_i |=> !rsp_valid_o);

  p_kseg0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_k && !req_user_i && req_vaddr_i[31:29] == 3'b100 |=>
      rsp_cause_o == 2'd0 && rsp_cached_o && rsp_paddr_o == $past(req_vaddr_i[28:0]));

  p_kseg1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_k && !req_user_i && req_vaddr_i[31:29] == 3'b101 |=>
      rsp_cause_o == 2'd0 && !rsp_cached_o && rsp_paddr_o == $past(req_vaddr_i[28:0]));

  p_hiseg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_k && !req_user_i && req_vaddr_i[31:30] == 2'b11 |=> rsp_cause_o == 2'd1);

  p_kpriv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_k && req_user_i && req_vaddr_i[31] |=> rsp_cause_o == 2'd3);

  p_cfgpriv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_kind_i == 2'd3 && req_user_i |=> rsp_cause_o == 2'd3);

  p_zero_on_exc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_exc_o |-> rsp_paddr_o == '0 && !rsp_cached_o && rsp_cause_o != 2'd0);
endmodule

bind addr_xlate_unit addr_xlate_unit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_vaddr_i  (req_vaddr_i),
  .req_kind_i   (req_kind_i),
  .req_user_i   (req_user_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_paddr_o  (rsp_paddr_o),
  .rsp_cached_o (rsp_cached_o),
  .rsp_exc_o    (rsp_exc_o),
  .rsp_cause_o  (rsp_cause_o)
);

// File: tb/addr_xlate_unit_test.sv
`timescale 1ns/1ps
module addr_xlate_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [28:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [28:0] rsp_paddr;
  logic        rsp_cached, rsp_exc;
  logic [1:0]  rsp_cause;

  always #2.5 clk = ~clk; // 200 MHz

  addr_xlate_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_kind_i(req_kind), .req_user_i(req_user),
    .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_paddr_o(rsp_paddr), .rsp_cached_o(rsp_cached),
    .rsp_exc_o(rsp_exc), .rsp_cause_o(rsp_cause)
  );

  typedef struct packed {
    logic [28:0] pa;
    logic        c;
    logic [1:0]  cs;
    logic [7:0]  rq;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0;
  bit   last_fire = 0, stall = 0, finished = 0;

  // reference state
  bit          m_uen = 0;
  longint      m_db = 0, m_ds = 0, m_pb = 0, m_ps = 0;
  localparam longint PROT = 64'h1F80_0000;

  task automatic check(input bit ok, input int r, input string what,
                       input longint got, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: got=%h exp=%h", r, what, got, exp);
    end
  endtask

  function automatic exp_t predict(input logic [1:0] k, input bit u, input logic [31:0] va);
    exp_t e = '0;
    longint base, size, off, p;
    if (k == 2'd3) begin
      e.rq = u ? 8'd10 : 8'd9;         // R10 / R9
      if (u) e.cs = 2'd3;
    end else if (va[31]) begin
      if (u) begin e.cs = 2'd3; e.rq = 8'd8; end  // R8
      else begin
        case (va[30:29])
          2'd0: begin e.pa = va[28:0]; e.c = 1; e.rq = 8'd2; end // R2
          2'd1: begin e.pa = va[28:0]; e.c = 0; e.rq = 8'd3; end // R3
          default: begin e.cs = 2'd1; e.rq = 8'd4; end           // R4
        endcase
      end
    end else if (!m_uen) begin
      e.cs = 2'd1; e.rq = 8'd5;        // R5
    end else begin
      base = (k == 2'd0) ? m_pb : m_db;
      size = (k == 2'd0) ? m_ps : m_ds;
      off  = longint'(va[30:0]);
      if (off >= size) begin e.cs = 2'd2; e.rq = 8'd6; end    // R6
      else begin
        p = base + off;
        if (p >= PROT) begin e.cs = 2'd2; e.rq = 8'd7; end    // R7
        else begin e.pa = p[28:0]; e.c = 1; e.rq = 8'd6; end
      end
    end
    return e;
  endfunction

  task automatic model_cfg(input logic [2:0] sel, input logic [28:0] wd);
    case (sel)
      3'd0: m_uen = wd[0];
      3'd1: m_db  = longint'(wd);
      3'd2: m_ds  = longint'(wd);
      3'd3: m_pb  = longint'(wd);
      3'd4: m_ps  = longint'(wd);
      default: ; // R9: no effect
    endcase
  endtask

  // per-cycle comparison just before each rising edge
  initial forever begin
    exp_t e;
    @(negedge clk);
    #2;
    if (rst_n && !finished) begin
      check(req_ready == (!rsp_valid || rsp_ready), 1, "ready rule", req_ready, !rsp_valid || rsp_ready);
      check(rsp_valid == (q.size() != 0), 1, "pending", rsp_valid, q.size() != 0);
      if (rsp_valid && rsp_ready && q.size() != 0) begin
        e = q.pop_front();
        check({rsp_pa_ok(e), rsp_exc == (e.cs != 0)} == 2'b11, int'(e.rq), "pa/c/cause",
              {rsp_paddr, rsp_cached, rsp_cause}, {e.pa, e.c, e.cs});
        if (rsp_exc && (rsp_paddr != 0 || rsp_cached))
          check(0, 11, "exc not zeroed", {rsp_paddr, rsp_cached}, 0); // R11
      end
      if (req_valid && req_ready) begin
        q.push_back(predict(req_kind, req_user, req_vaddr));
        if (req_kind == 2'd3 && !req_user) model_cfg(req_vaddr[2:0], req_wdata);
        last_fire = 1;
      end else last_fire = 0;
    end
  end

  function automatic bit rsp_pa_ok(input exp_t e);
    return rsp_paddr == e.pa && rsp_cached == e.c && rsp_cause == e.cs;
  endfunction

  initial forever begin
    @(negedge clk);
    rsp_ready = stall ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic issue(input logic [1:0] k, input bit u, input logic [31:0] va,
                       input logic [28:0] wd);
    req_kind = k; req_user = u; req_vaddr = va; req_wdata = wd; req_valid = 1'b1;
    do @(posedge clk); while (!last_fire);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: got=hang exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: idle out of reset
    check(rsp_valid == 0, 12, "rsp_valid in reset", rsp_valid, 0);
    check(req_ready == 1, 12, "req_ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 0 && req_ready == 1, 12, "idle after reset", {rsp_valid, req_ready}, 2'b01);

    issue(2'd1, 0, 32'h0000_0100, '0);          // R12/R5: user seg closed
    issue(2'd0, 0, 32'h8000_1234, '0);          // R2
    issue(2'd1, 0, 32'h9FFF_FFFC, '0);          // R2 top
    issue(2'd2, 0, 32'hA000_0040, '0);          // R3
    issue(2'd0, 0, 32'hBFC0_0000, '0);          // R3
    issue(2'd1, 0, 32'hC000_0000, '0);          // R4
    issue(2'd2, 0, 32'hFFFF_FFFF, '0);          // R4
    issue(2'd1, 1, 32'h8000_0000, '0);          // R8
    issue(2'd0, 1, 32'hE000_0000, '0);          // R8 over cause 1
    issue(2'd3, 1, 32'h0000_0000, 29'd1);       // R10: ignored
    issue(2'd1, 1, 32'h0000_0010, '0);          // R10 proof: still closed (R5)
    issue(2'd3, 0, 32'h0000_0001, 29'h0010_0000); // R9 data base
    issue(2'd3, 0, 32'h0000_0002, 29'h0002_0000); // data size
    issue(2'd3, 0, 32'h0000_0003, 29'h0000_4000); // prog base
    issue(2'd3, 0, 32'h0000_0004, 29'h0000_1000); // prog size
    issue(2'd1, 1, 32'h0000_0000, '0);          // still closed
    issue(2'd3, 0, 32'h0000_0000, 29'd1);       // open user seg
    issue(2'd1, 1, 32'h0000_0000, '0);          // R6 base
    issue(2'd2, 1, 32'h0001_FFFF, '0);          // R6 last byte
    issue(2'd1, 1, 32'h0002_0000, '0);          // R6 past size
    issue(2'd0, 1, 32'h0000_0FFF, '0);          // R6 fetch partition
    issue(2'd0, 1, 32'h0000_1000, '0);          // R6 fetch past size
    issue(2'd1, 1, 32'h7FFF_0000, '0);          // R6 huge offset
    issue(2'd3, 0, 32'h0000_0005, 29'h1234);    // R9 no-effect selector
    issue(2'd1, 1, 32'h0000_0800, '0);          // R9 proof: unchanged map
    issue(2'd3, 0, 32'h0000_0001, 29'h1F7F_F000); // R7 base near protected
    issue(2'd3, 0, 32'h0000_0002, 29'h0010_0000);
    issue(2'd1, 1, 32'h0000_0FFF, '0);          // R7 just below
    issue(2'd1, 1, 32'h0000_1000, '0);          // R7 hits PROT_BASE
    issue(2'd3, 0, 32'h0000_0001, 29'h1FFF_FFF0); // R7 overflow
    issue(2'd3, 0, 32'h0000_0002, 29'h1FFF_FFFF);
    issue(2'd2, 1, 32'h0000_0020, '0);

    // R1: backpressure with back-to-back traffic, random mix
    stall = 1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] va;
      logic [1:0]  k;
      k  = 2'($urandom % 4);
      va = $urandom;
      if ((i % 3) == 0) va[31] = 1'b0;
      if (k == 2'd3 && va[2:0] == 3'd0 && (i % 2) == 0) va[2:0] = 3'd1;
      issue(k, bit'($urandom % 2), va, 29'($urandom % 32'h0030_0000));
    end
    stall = 0;
    repeat (6) @(negedge clk);
    check(q.size() == 0, 1, "drained", q.size(), 0);
    finish_run();
  end
endmodule